// File: doc/BRIEF.md
# APB Control and Status Register File

This block is the register front end for a four-channel data formatter. An APB master configures each channel through four packed control words: a channel-enable mask, a per-channel parity-error-clear mask, a word of four 8-bit channel IDs and a word of four 8-bit packet lengths. Each of these drives a port toward the datapath. In the other direction, the block samples each channel's 6-bit free FIFO slot count and 1-bit parity error flag on every clock and returns them in eight read-only words.

Transfers use the usual two-phase APB handshake. A setup cycle has select high and enable low. An access cycle has both high. The slave answers with zero wait states: ready is high for the single access cycle, read data is valid in that same cycle, and a write takes effect at the clock edge that ends the access cycle. The error response marks accesses the map cannot honour. These are unmapped or unaligned offsets, and writes aimed at read-only words. In these cases nothing changes and any read data is zero.

Top module: `csr_apb_regfile`

## Requirements
- R1: A synchronous active-low reset clears the enable mask, the clear mask, all IDs and all lengths to zero, and holds ready and error low.
- R2: Ready is high only in an access cycle (select and enable both high). It stays low in a setup cycle. Every access cycle gets ready with no wait state.
- R3: Offset 0x00 holds the channel-enable mask. A write stores wdata[3:0], bit n enables channel n and drives chan_enable[n]. A read returns the mask in bits [3:0] with bits [31:4] zero.
- R4: Offset 0x04 holds the parity-error-clear mask. A write stores wdata[3:0] and drives chan_err_clear. A read returns the mask in bits [3:0] with bits [31:4] zero.
- R5: Offset 0x08 holds the channel IDs, with channel n in bits [8n+7:8n]. A write drives chan_id with the same packing, and a read returns it unchanged.
- R6: Offset 0x0C holds the packet lengths, with channel n in bits [8n+7:8n]. A write drives chan_len with the same packing, and a read returns it unchanged.
- R7: A read of offset 0x80+4n returns channel n's free-slot count (chan_free_slots[6n+5:6n]) in bits [5:0] with the upper bits zero. The count is sampled on every clock, so it follows a change of the input.
- R8: A read of offset 0x90+4n returns channel n's parity error flag (chan_parity_err[n]) in bit 0 with the upper bits zero.
- R9: A write to any read-only offset (0x80..0x9C) raises error in its access cycle. It leaves every readable value unchanged.
- R10: An access to an unmapped offset, or to an offset whose two low bits are not zero, raises error in its access cycle. Such a read returns zero, and such a write changes no register.
- R11: Registers change only at the end of a write access cycle. A setup cycle that is not followed by enable writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | APB select |
| bus_en | input | 1 | APB enable (access phase) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| bus_ready | output | 1 | Transfer complete |
| bus_err | output | 1 | Error response |
| chan_enable | output | 4 | Per-channel enable |
| chan_err_clear | output | 4 | Per-channel parity error clear |
| chan_id | output | 32 | Packed 8-bit channel IDs |
| chan_len | output | 32 | Packed 8-bit packet lengths |
| chan_free_slots | input | 24 | Packed 6-bit free-slot counts |
| chan_parity_err | input | 4 | Per-channel parity error flags |

## Verification
The assertions check several properties on every cycle. Ready appears only in access cycles. Reset quiets both responses. An error read carries zero data. Writes to read-only offsets are always flagged. The control ports move only after a write access cycle, and the enable and ID words take the written data. A free-slot read returns the count sampled one edge earlier. The exact address map still needs the bench scenarios. These cover each channel's field placement, per-channel status offsets, the unaligned and unmapped holes, and proof that a rejected or setup-only write left every readable word as it was.

// File: rtl/csr_apb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the APB register file: region codes and map bases.
// Assumes four words per region, so the word index is address bits [3:2].
package csr_apb_pkg;
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_CTRL = 2'd1,
        RGN_FREE = 2'd2,
        RGN_PAR  = 2'd3
    } region_e;

    localparam logic [3:0] CTRL_PAGE = 4'h0;
    localparam logic [3:0] FREE_PAGE = 4'h8;
    localparam logic [3:0] PAR_PAGE  = 4'h9;

    localparam int CTRL_WORDS = 4;
    localparam int WIDX_W     = 2;
endpackage

// File: rtl/csr_addr_decode.sv
`timescale 1ns/1ps
// Address decoder: classifies a byte address into a register region and a
// word index. Assumes 16-byte pages of four 32-bit words. An address with
// nonzero low bits, or on an unlisted page, decodes as no region.
module csr_addr_decode
    import csr_apb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [WIDX_W-1:0] widx
);
    localparam int PAGE_LSB = WIDX_W + 2;

    logic                     aligned;
    logic [ADDR_W-PAGE_LSB-1:0] page;

    // Split the address into page, word index and byte offset.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        page    = addr[ADDR_W-1:PAGE_LSB];
        widx    = addr[PAGE_LSB-1:2];
    end

    // Map the page to a region; misaligned accesses fall through.
    always_comb begin
        region = RGN_NONE;
        if (aligned) begin
            if (page == (ADDR_W-PAGE_LSB)'(CTRL_PAGE))      region = RGN_CTRL;
            else if (page == (ADDR_W-PAGE_LSB)'(FREE_PAGE)) region = RGN_FREE;
            else if (page == (ADDR_W-PAGE_LSB)'(PAR_PAGE))  region = RGN_PAR;
        end
    end
endmodule

// File: rtl/csr_ctrl_regs.sv
`timescale 1ns/1ps
// Writable control words: enable mask (word 0), error-clear mask (word 1),
// packed IDs (word 2), packed lengths (word 3). The caller qualifies wr_en
// with a completed write access; unused upper bits read as zero.
module csr_ctrl_regs
    import csr_apb_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NCH     = 4,
    parameter int FIELD_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WIDX_W-1:0]      widx,
    input  logic [DATA_W-1:0]      wdata,
    output logic [NCH-1:0]         en_mask,
    output logic [NCH-1:0]         clr_mask,
    output logic [NCH*FIELD_W-1:0] ids,
    output logic [NCH*FIELD_W-1:0] lens,
    output logic [DATA_W-1:0]      rd_word
);
    localparam int PACK_W = NCH * FIELD_W;

    logic [CTRL_WORDS-1:0] wsel;

    // One-hot word select for the write strobe.
    always_comb begin
        wsel = '0;
        if (wr_en) wsel[widx] = 1'b1;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       en_mask <= '0;
        else if (wsel[0]) en_mask <= wdata[NCH-1:0];
    end

    // Error-clear mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)       clr_mask <= '0;
        else if (wsel[1]) clr_mask <= wdata[NCH-1:0];
    end

    // Packed channel ID register.
    always_ff @(posedge clk) begin
        if (!rst_n)       ids <= '0;
        else if (wsel[2]) ids <= wdata[PACK_W-1:0];
    end

    // Packed packet-length register.
    always_ff @(posedge clk) begin
        if (!rst_n)       lens <= '0;
        else if (wsel[3]) lens <= wdata[PACK_W-1:0];
    end

    // Readback mux with zero extension.
    always_comb begin
        case (widx)
            2'd0:    rd_word = DATA_W'(en_mask);
            2'd1:    rd_word = DATA_W'(clr_mask);
            2'd2:    rd_word = DATA_W'(ids);
            default: rd_word = DATA_W'(lens);
        endcase
    end
endmodule

// File: rtl/csr_status_capture.sv
`timescale 1ns/1ps
// Read-only status words: registers each channel's free-slot count and parity
// flag on every clock, with no enable and no reset, so a read sees the input
// as of the previous edge. The bus cannot write these registers.
module csr_status_capture
    import csr_apb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NCH    = 4,
    parameter int SLOT_W = 6
) (
    input  logic                  clk,
    input  logic [NCH*SLOT_W-1:0] free_in,
    input  logic [NCH-1:0]        par_in,
    input  logic [WIDX_W-1:0]     widx,
    input  logic                  pick_par,
    output logic [DATA_W-1:0]     rd_word
);
    logic [SLOT_W-1:0] free_q [NCH];
    logic [NCH-1:0]    par_q;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        // Per-channel status sample.
        always_ff @(posedge clk) begin
            free_q[ch] <= free_in[ch*SLOT_W +: SLOT_W];
            par_q[ch]  <= par_in[ch];
        end
    end

    // Select the addressed status word, zero-extended.
    always_comb begin
        if (pick_par) rd_word = DATA_W'(par_q[widx]);
        else          rd_word = DATA_W'(free_q[widx]);
    end
endmodule

// File: rtl/csr_apb_regfile.sv
`timescale 1ns/1ps
// APB slave register file for a four-channel formatter. Zero wait states:
// ready in every access cycle, writes commit at the end of it. Errors on
// unmapped/misaligned offsets and on writes to read-only words.
module csr_apb_regfile
    import csr_apb_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NCH     = 4,
    parameter int FIELD_W = 8,
    parameter int SLOT_W  = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_sel,
    input  logic                   bus_en,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_ready,
    output logic                   bus_err,
    output logic [NCH-1:0]         chan_enable,
    output logic [NCH-1:0]         chan_err_clear,
    output logic [NCH*FIELD_W-1:0] chan_id,
    output logic [NCH*FIELD_W-1:0] chan_len,
    input  logic [NCH*SLOT_W-1:0]  chan_free_slots,
    input  logic [NCH-1:0]         chan_parity_err
);
    region_e           region;
    logic [WIDX_W-1:0] widx;
    logic              access;
    logic              reject;
    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] stat_word;

    csr_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .region (region),
        .widx   (widx)
    );

    // Access qualification and error classification.
    always_comb begin
        access  = rst_n && bus_sel && bus_en;
        reject  = (region == RGN_NONE) || (bus_write && region != RGN_CTRL);
        ctrl_wr = access && bus_write && (region == RGN_CTRL);
    end

    csr_ctrl_regs #(.DATA_W(DATA_W), .NCH(NCH), .FIELD_W(FIELD_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ctrl_wr),
        .widx     (widx),
        .wdata    (bus_wdata),
        .en_mask  (chan_enable),
        .clr_mask (chan_err_clear),
        .ids      (chan_id),
        .lens     (chan_len),
        .rd_word  (ctrl_word)
    );

    csr_status_capture #(.DATA_W(DATA_W), .NCH(NCH), .SLOT_W(SLOT_W)) u_stat (
        .clk      (clk),
        .free_in  (chan_free_slots),
        .par_in   (chan_parity_err),
        .widx     (widx),
        .pick_par (region == RGN_PAR),
        .rd_word  (stat_word)
    );

    // Bus responses: zero-wait ready, error, and read data mux.
    always_comb begin
        bus_ready = access;
        bus_err   = access && reject;
        bus_rdata = '0;
        if (access && !bus_write && !reject)
            bus_rdata = (region == RGN_CTRL) ? ctrl_word : stat_word;
    end
endmodule

// File: rtl/csr_apb_checker.sv
`timescale 1ns/1ps
// Protocol and map checker for csr_apb_regfile, attached with bind below.
module csr_apb_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int NCH     = 4,
    parameter int FIELD_W = 8,
    parameter int SLOT_W  = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_sel,
    input logic                   bus_en,
    input logic                   bus_write,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic                   bus_ready,
    input logic                   bus_err,
    input logic [NCH-1:0]         chan_enable,
    input logic [NCH-1:0]         chan_err_clear,
    input logic [NCH*FIELD_W-1:0] chan_id,
    input logic [NCH*FIELD_W-1:0] chan_len,
    input logic [NCH*SLOT_W-1:0]  chan_free_slots
);
    logic acc_wr;
    logic acc_rd;
    always_comb begin
        acc_wr = bus_sel && bus_en && bus_write;
        acc_rd = bus_sel && bus_en && !bus_write;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |-> (!bus_ready && !bus_err));

    assert_ready_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |-> (bus_sel && bus_en));

    assert_enable_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr == ADDR_W'('h00)) |=> chan_enable == $past(bus_wdata[NCH-1:0]));

    assert_id_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr == ADDR_W'('h08)) |=> chan_id == $past(bus_wdata[NCH*FIELD_W-1:0]));

    assert_free_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr == ADDR_W'('h80)) |-> bus_rdata == DATA_W'($past(chan_free_slots[SLOT_W-1:0])));

    assert_ro_write_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && bus_addr[ADDR_W-1]) |-> bus_err);

    assert_err_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !bus_write) |-> bus_rdata == '0);

    assert_hold_outside_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> ($stable(chan_enable) && $stable(chan_err_clear)
                     && $stable(chan_id) && $stable(chan_len)));
endmodule

bind csr_apb_regfile csr_apb_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .FIELD_W(FIELD_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_en          (bus_en),
    .bus_write       (bus_write),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .bus_ready       (bus_ready),
    .bus_err         (bus_err),
    .chan_enable     (chan_enable),
    .chan_err_clear  (chan_err_clear),
    .chan_id         (chan_id),
    .chan_len        (chan_len),
    .chan_free_slots (chan_free_slots)
);

// File: tb/csr_apb_regfile_test.sv
`timescale 1ns/1ps
// Scoreboard bench: xfer() queues the expected response, the monitor pops and
// compares it in the access cycle at the falling edge.
module csr_apb_regfile_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        bus_err;
    logic [3:0]  chan_enable;
    logic [3:0]  chan_err_clear;
    logic [31:0] chan_id;
    logic [31:0] chan_len;
    logic [23:0] chan_free_slots = '0;
    logic [3:0]  chan_parity_err = '0;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [31:0] q_data[$];
    logic        q_err[$];
    logic        q_rd[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    csr_apb_regfile uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_en(bus_en),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_err(bus_err),
        .chan_enable(chan_enable), .chan_err_clear(chan_err_clear),
        .chan_id(chan_id), .chan_len(chan_len),
        .chan_free_slots(chan_free_slots), .chan_parity_err(chan_parity_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] wd,
                        input logic [31:0] exp_d, input bit exp_e, input string tag);
        q_data.push_back(exp_d);
        q_err.push_back(exp_e);
        q_rd.push_back(!wr);
        q_tag.push_back(tag);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_en = 1'b0; bus_write = wr; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        chk("R2 setup ready", 32'(bus_ready), 32'd0);
        @(posedge clk); #1;
        bus_en = 1'b1;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_en = 1'b0;
    endtask

    // Monitor: compare each access cycle against the queued expectation.
    always @(negedge clk) begin
        if (bus_sel && bus_en) begin
            if (q_tag.size() == 0) begin
                total++; bad++;
                $display("FAIL R2: unexpected access actual=1 expected=0");
            end else begin
                automatic string t = q_tag.pop_front();
                automatic logic [31:0] d = q_data.pop_front();
                automatic logic e = q_err.pop_front();
                automatic logic r = q_rd.pop_front();
                chk({"R2 ready ", t}, 32'(bus_ready), 32'd1);
                chk({t, " err"}, 32'(bus_err), 32'(e));
                if (r) chk({t, " rdata"}, bus_rdata, d);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 enable", 32'(chan_enable), 32'd0);
        chk("R1 clear", 32'(chan_err_clear), 32'd0);
        chk("R1 id", chan_id, 32'd0);
        chk("R1 len", chan_len, 32'd0);
        chk("R1 ready", 32'(bus_ready), 32'd0);
        chk("R1 err", 32'(bus_err), 32'd0);
        @(posedge clk); #1 rst_n = 1'b1;

        xfer(1'b0, 8'h00, '0, 32'h0, 1'b0, "R1 read enable");
        xfer(1'b0, 8'h0C, '0, 32'h0, 1'b0, "R1 read len");

        xfer(1'b1, 8'h00, 32'hFFFF_FFFA, '0, 1'b0, "R3 write");
        @(negedge clk); chk("R3 port", 32'(chan_enable), 32'hA);
        xfer(1'b0, 8'h00, '0, 32'h0000_000A, 1'b0, "R3 read");

        xfer(1'b1, 8'h04, 32'h8765_4325, '0, 1'b0, "R4 write");
        @(negedge clk); chk("R4 port", 32'(chan_err_clear), 32'h5);
        xfer(1'b0, 8'h04, '0, 32'h0000_0005, 1'b0, "R4 read");

        xfer(1'b1, 8'h08, 32'h4433_2211, '0, 1'b0, "R5 write");
        @(negedge clk); chk("R5 port", chan_id, 32'h4433_2211);
        xfer(1'b0, 8'h08, '0, 32'h4433_2211, 1'b0, "R5 read");

        xfer(1'b1, 8'h0C, 32'hDDCC_BBAA, '0, 1'b0, "R6 write");
        @(negedge clk); chk("R6 port", chan_len, 32'hDDCC_BBAA);
        xfer(1'b0, 8'h0C, '0, 32'hDDCC_BBAA, 1'b0, "R6 read");

        chan_free_slots = {6'd40, 6'd63, 6'd22, 6'd1};
        xfer(1'b0, 8'h80, '0, 32'd1,  1'b0, "R7 ch0");
        xfer(1'b0, 8'h84, '0, 32'd22, 1'b0, "R7 ch1");
        xfer(1'b0, 8'h88, '0, 32'd63, 1'b0, "R7 ch2");
        xfer(1'b0, 8'h8C, '0, 32'd40, 1'b0, "R7 ch3");
        chan_free_slots[17:12] = 6'd0;
        xfer(1'b0, 8'h88, '0, 32'd0,  1'b0, "R7 ch2 follows");

        chan_parity_err = 4'b1010;
        xfer(1'b0, 8'h90, '0, 32'd0, 1'b0, "R8 ch0");
        xfer(1'b0, 8'h94, '0, 32'd1, 1'b0, "R8 ch1");
        xfer(1'b0, 8'h98, '0, 32'd0, 1'b0, "R8 ch2");
        xfer(1'b0, 8'h9C, '0, 32'd1, 1'b0, "R8 ch3");

        xfer(1'b1, 8'h84, 32'hFFFF_FFFF, '0, 1'b1, "R9 write free");
        xfer(1'b0, 8'h84, '0, 32'd22, 1'b0, "R9 free kept");
        xfer(1'b1, 8'h94, 32'h0, '0, 1'b1, "R9 write parity");
        xfer(1'b0, 8'h94, '0, 32'd1, 1'b0, "R9 parity kept");
        xfer(1'b0, 8'h00, '0, 32'h0000_000A, 1'b0, "R9 ctrl kept");

        xfer(1'b0, 8'h10, '0, 32'h0, 1'b1, "R10 unmapped read");
        xfer(1'b0, 8'h02, '0, 32'h0, 1'b1, "R10 misaligned read");
        xfer(1'b0, 8'hA0, '0, 32'h0, 1'b1, "R10 high unmapped read");
        xfer(1'b1, 8'h40, 32'hFFFF_FFFF, '0, 1'b1, "R10 unmapped write");
        xfer(1'b1, 8'h01, 32'h0, '0, 1'b1, "R10 misaligned write");
        xfer(1'b0, 8'h00, '0, 32'h0000_000A, 1'b0, "R10 enable kept");
        xfer(1'b0, 8'h04, '0, 32'h0000_0005, 1'b0, "R10 clear kept");
        @(negedge clk); chk("R10 id port", chan_id, 32'h4433_2211);

        @(posedge clk); #1;
        bus_sel = 1'b1; bus_en = 1'b0; bus_write = 1'b1; bus_addr = 8'h00; bus_wdata = 32'h3;
        @(posedge clk); #1;
        bus_sel = 1'b0;
        @(negedge clk); chk("R11 setup only", 32'(chan_enable), 32'hA);
        xfer(1'b0, 8'h00, '0, 32'h0000_000A, 1'b0, "R11 read");

        repeat (3) @(posedge clk);
        if (q_tag.size() != 0) chk("R2 pending", 32'(q_tag.size()), 32'd0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule